// File: doc/BRIEF.md
# Virtual Address Translator with Protection Check

This block turns a 32-bit virtual address into a physical address for one of three access kinds: data read, data write or instruction fetch. It first sorts the address into fixed regions. Some regions bypass translation. In privileged mode those regions map straight through; in user mode most of them are forbidden. All other addresses go to a fully associative table of page entries when translation is enabled. Each entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, a shared flag, two permission bits and a dirty bit. When translation is disabled, the low 29 address bits pass through.

A request is presented for one cycle on `req`. One clock later, `rsp_valid` is high for one cycle. At the same time `rsp_code` carries 0 for success or an exception code, and `rsp_pa` carries the physical address. `rsp_pa` is zero whenever a fault is reported. Entries are written through a load port into the slot named by a replacement pointer. The pointer advances on every lookup that reaches the table and wraps at a programmable limit.

The control path is a two-state machine. `S_IDLE` means no result is presented. `S_HOLD` means a result is presented this cycle. There are three transitions:
- *issue*: `S_IDLE` to `S_HOLD` on `req`.
- *chain*: `S_HOLD` to `S_HOLD` on `req`.
- *drain*: `S_HOLD` to `S_IDLE` without `req`.

The result registers keep their last value while idle.

Top module: `vat_xlate`

## Requirements
- R1: In privileged mode, an address whose top two bits are `10` (0x80000000 to 0xBFFFFFFF) returns code 0 and physical address {3'b000, va[28:0]}. An address at or above 0xE0000000 returns code 0 and the address unchanged.
- R2: In user mode, an untranslated-region address outside 0xE0000000 to 0xE3FFFFFF faults. The code is 0x0C0 for a read or fetch and 0x100 for a write. Inside that window the address passes unchanged with code 0. This region check happens before anything else, even when translation is off.
- R3: With `xlate_en` = 0, any other address returns code 0 and physical address va & 0x1FFFFFFF.
- R4: Entry page-size code 0, 1, 2 or 3 selects 1 KB, 4 KB, 64 KB or 1 MB. The match base is {vpn, 10'b0} with the in-page bits cleared. The physical address is ({ppn, 10'b0} with the in-page bits cleared) OR the in-page bits of va.
- R5: The address-space tag is compared only when `single_space` = 0 or the access is in user mode. An entry with the shared flag set matches any tag. An entry with its valid bit clear never matches.
- R6: More than one matching entry gives code 0x140.
- R7: No matching entry gives 0x040 for a read or fetch and 0x060 for a write.
- R8: In user mode, a hit on an entry whose `perm[1]` = 0 gives 0x0A0 for a read or fetch and 0x0C0 for a write.
- R9: Otherwise, a write to an entry with `perm[0]` = 0 gives 0x0C0. A write to an entry with dirty = 0 gives 0x080. Reads and fetches ignore both bits.
- R10: The replacement pointer advances by one on each lookup that reaches the table, and on nothing else. The next value becomes 0 if `wrap_lim` != 0 and the next value exceeds `wrap_lim`, or if it exceeds ENTRIES-1.
- R11: `ld_en` writes the load-port fields into the slot named by the replacement pointer, and does not move the pointer.
- R12: `rsp_valid` is high exactly one cycle after each `req` cycle. `rsp_code` and `rsp_pa` change only on a request. On a fault, `rsp_pa` is 0. Access encoding: 0 = read, 1 = write, 2 = fetch, 3 = read.
- R13: Reset clears `rsp_valid`, `rsp_code`, `rsp_pa` and the pointer, and invalidates every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Lookup request |
| acc | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 read) |
| va | input | 32 | Virtual address |
| priv | input | 1 | Privileged mode |
| xlate_en | input | 1 | Translation enable |
| single_space | input | 1 | Skip tag compare in privileged mode |
| cur_asid | input | 8 | Current address-space tag |
| wrap_lim | input | IDX_W | Replacement pointer wrap limit (0 = full range) |
| ld_en | input | 1 | Write an entry |
| ld_valid | input | 1 | Entry valid bit |
| ld_vpn | input | 22 | Entry virtual page number |
| ld_asid | input | 8 | Entry address-space tag |
| ld_sz | input | 2 | Entry page-size code |
| ld_shared | input | 1 | Entry shared flag |
| ld_perm | input | 2 | Entry permissions (bit 1 user, bit 0 write) |
| ld_dirty | input | 1 | Entry dirty bit |
| ld_ppn | input | 19 | Entry physical page number |
| rsp_valid | output | 1 | Result valid |
| rsp_code | output | 12 | Exception code, 0 on success |
| rsp_pa | output | 32 | Physical address |
| repl_ptr | output | IDX_W | Replacement pointer |

## Verification
The lookup is tried with each page size at in-page offsets, including the last byte of a page and the first byte beyond it. The same entries are then read, written and fetched in both modes, so that every permission and dirty combination lands on its own code. Tag patterns include a foreign tag with the compare enabled, the same tag with the compare bypassed, and a shared entry. Together these separate tag gating from address matching. Overlapping entries of different sizes tell a multiple hit apart from a single hit. Pointer sequences with a small and a zero wrap limit, interleaved with bypassed accesses and loads, show where the pointer moves and which slot a load overwrites.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } st_e;

    localparam logic [CODE_W-1:0] FC_NONE      = 12'h000;
    localparam logic [CODE_W-1:0] FC_MISS_RD   = 12'h040;
    localparam logic [CODE_W-1:0] FC_MISS_WR   = 12'h060;
    localparam logic [CODE_W-1:0] FC_FIRST_WR  = 12'h080;
    localparam logic [CODE_W-1:0] FC_PROT_RD   = 12'h0A0;
    localparam logic [CODE_W-1:0] FC_PROT_WR   = 12'h0C0;
    localparam logic [CODE_W-1:0] FC_AERR_RD   = 12'h0C0;
    localparam logic [CODE_W-1:0] FC_AERR_WR   = 12'h100;
    localparam logic [CODE_W-1:0] FC_MULTI     = 12'h140;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [1:0]        sz;
        logic              shared;
        logic [1:0]        perm;
        logic              dirty;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    // Bits of va[31:10] that take part in the page match for a size code.
    function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
        unique case (sz)
            2'd0: vpn_keep = {VPN_W{1'b1}};
            2'd1: vpn_keep = {{(VPN_W-2){1'b1}}, 2'b0};
            2'd2: vpn_keep = {{(VPN_W-6){1'b1}}, 6'b0};
            default: vpn_keep = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction

endpackage

// File: rtl/vat_region.sv
module vat_region (
    input  logic [31:0] va,
    input  logic        priv,
    output logic        untrans,
    output logic        addr_err,
    output logic [31:0] fixed_pa
);
    logic in_p12, in_p4, in_sq;

    assign in_p12   = (va[31:30] == 2'b10);
    assign in_p4    = (va[31:29] == 3'b111);
    assign in_sq    = (va[31:26] == 6'b111000);
    assign untrans  = in_p12 | in_p4;
    assign addr_err = untrans & ~priv & ~in_sq;
    assign fixed_pa = in_p12 ? {3'b000, va[28:0]} : va;
endmodule

// File: rtl/vat_tlb.sv
module vat_tlb
    import vat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  tlb_ent_t          ld_ent,
    input  logic [31:0]       va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              asid_chk,
    output logic              hit,
    output logic              multi,
    output tlb_ent_t          sel
);
    tlb_ent_t           ents [ENTRIES];
    logic [ENTRIES-1:0] hits;

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                ents[i].valid <= 1'b0;
            end else if (ld_en && ld_idx == IDX_W'(i)) begin
                ents[i] <= ld_ent;
            end
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            logic [VPN_W-1:0] keep;
            assign keep    = vpn_keep(ents[g].sz);
            assign hits[g] = ents[g].valid
                           & (ents[g].shared | ~asid_chk | (ents[g].asid == cur_asid))
                           & ((va[31:10] & keep) == (ents[g].vpn & keep));
        end
    endgenerate

    assign hit   = |hits;
    assign multi = |(hits & (hits - 1'b1));

    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) sel = ents[i];
        end
    end

    // R11: a load lands in the addressed slot
    a_r11_load_lands: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ents[$past(ld_idx)] == $past(ld_ent));
endmodule

// File: rtl/vat_repl.sv
module vat_repl #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [IDX_W-1:0] wrap_lim,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W:0] nxt;
    logic           wrap;

    assign nxt  = {1'b0, ptr} + 1'b1;
    assign wrap = ((wrap_lim != '0) && (nxt > {1'b0, wrap_lim}))
                || (nxt > (IDX_W+1)'(ENTRIES - 1));

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (tick) ptr <= wrap ? '0 : nxt[IDX_W-1:0];
    end

    // R10: pointer only moves on a table lookup
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ptr));
    // R10: below the limit the pointer steps by one
    a_r10_step: assert property (@(posedge clk) disable iff (rst)
        (tick && wrap_lim != '0 && ptr < wrap_lim) |=> ptr == $past(ptr) + 1'b1);
    // R10: a step either increments or wraps to zero
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ptr == '0 || ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
    import vat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        acc,
    input  logic [31:0]       va,
    input  logic              priv,
    input  logic              xlate_en,
    input  logic              single_space,
    input  logic [7:0]        cur_asid,
    input  logic [IDX_W-1:0]  wrap_lim,
    input  logic              ld_en,
    input  logic              ld_valid,
    input  logic [21:0]       ld_vpn,
    input  logic [7:0]        ld_asid,
    input  logic [1:0]        ld_sz,
    input  logic              ld_shared,
    input  logic [1:0]        ld_perm,
    input  logic              ld_dirty,
    input  logic [18:0]       ld_ppn,
    output logic              rsp_valid,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_pa,
    output logic [IDX_W-1:0]  repl_ptr
);
    st_e               state, state_nx;
    logic              rg_untrans, rg_err;
    logic [31:0]       rg_pa;
    logic              t_hit, t_multi;
    tlb_ent_t          t_sel, ld_ent;
    logic              is_wr, tlb_use;
    logic [31:0]       ofs_mask, tlb_pa;
    logic [CODE_W-1:0] nx_code;
    logic [31:0]       nx_pa;

    assign is_wr = (acc_e'(acc) == ACC_WRITE);

    assign ld_ent = '{valid: ld_valid, vpn: ld_vpn, asid: ld_asid, sz: ld_sz,
                      shared: ld_shared, perm: ld_perm, dirty: ld_dirty, ppn: ld_ppn};

    vat_region u_region (
        .va       (va),
        .priv     (priv),
        .untrans  (rg_untrans),
        .addr_err (rg_err),
        .fixed_pa (rg_pa)
    );

    vat_tlb #(.ENTRIES(ENTRIES)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_idx   (repl_ptr),
        .ld_ent   (ld_ent),
        .va       (va),
        .cur_asid (cur_asid),
        .asid_chk (~single_space | ~priv),
        .hit      (t_hit),
        .multi    (t_multi),
        .sel      (t_sel)
    );

    vat_repl #(.ENTRIES(ENTRIES)) u_repl (
        .clk      (clk),
        .rst      (rst),
        .tick     (req & tlb_use),
        .wrap_lim (wrap_lim),
        .ptr      (repl_ptr)
    );

    assign ofs_mask = {~vpn_keep(t_sel.sz), 10'h3FF};
    assign tlb_pa   = ({3'b000, t_sel.ppn, 10'b0} & ~ofs_mask) | (va & ofs_mask);

    // Result selection, in order of precedence
    always_comb begin
        nx_code = FC_NONE;
        nx_pa   = '0;
        tlb_use = 1'b0;
        if (rg_untrans) begin
            if (rg_err) nx_code = is_wr ? FC_AERR_WR : FC_AERR_RD;
            else        nx_pa   = rg_pa;
        end else if (!xlate_en) begin
            nx_pa = {3'b000, va[28:0]};
        end else begin
            tlb_use = 1'b1;
            if (t_multi)                         nx_code = FC_MULTI;
            else if (!t_hit)                     nx_code = is_wr ? FC_MISS_WR : FC_MISS_RD;
            else if (!priv && !t_sel.perm[1])    nx_code = is_wr ? FC_PROT_WR : FC_PROT_RD;
            else if (is_wr && !t_sel.perm[0])    nx_code = FC_PROT_WR;
            else if (is_wr && !t_sel.dirty)      nx_code = FC_FIRST_WR;
            else                                 nx_pa   = tlb_pa;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req)  state_nx = S_HOLD;   // issue
            S_HOLD: if (!req) state_nx = S_IDLE;   // drain; chain stays
            default:          state_nx = S_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_code <= FC_NONE;
            rsp_pa   <= '0;
        end else if (req) begin
            rsp_code <= nx_code;
            rsp_pa   <= nx_pa;
        end
    end

    assign rsp_valid = (state == S_HOLD);

    // R12: valid follows a request by one cycle
    a_r12_req_valid: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);
    a_r12_no_req: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rsp_valid);
    // R12: result held between requests
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(rsp_code) && $stable(rsp_pa)));
    // R1: privileged direct region drops the top three bits
    a_r1_direct: assert property (@(posedge clk) disable iff (rst)
        (req && priv && va[31:30] == 2'b10) |=>
            (rsp_code == FC_NONE && rsp_pa == {3'b000, $past(va[28:0])}));
    // R2: user mode never reaches the direct region
    a_r2_user_block: assert property (@(posedge clk) disable iff (rst)
        (req && !priv && va[31:30] == 2'b10) |=> (rsp_code != FC_NONE && rsp_pa == '0));
endmodule

// File: tb/tb_vat_xlate.sv
`timescale 1ns/1ps
module tb_vat_xlate;
    localparam int ENTRIES = 64;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int VW      = 89;
    localparam int NV      = 40;

    logic clk = 1'b0;
    logic rst;
    logic req;
    logic [1:0] acc;
    logic [31:0] va;
    logic priv, xlate_en, single_space;
    logic [7:0] cur_asid;
    logic [IDX_W-1:0] wrap_lim;
    logic ld_en, ld_valid, ld_shared, ld_dirty;
    logic [21:0] ld_vpn;
    logic [7:0] ld_asid;
    logic [1:0] ld_sz, ld_perm;
    logic [18:0] ld_ppn;
    logic rsp_valid;
    logic [11:0] rsp_code;
    logic [31:0] rsp_pa;
    logic [IDX_W-1:0] repl_ptr;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr;

    always #10 clk = ~clk;

    vat_xlate #(.ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst(rst), .req(req), .acc(acc), .va(va), .priv(priv),
        .xlate_en(xlate_en), .single_space(single_space), .cur_asid(cur_asid),
        .wrap_lim(wrap_lim), .ld_en(ld_en), .ld_valid(ld_valid), .ld_vpn(ld_vpn),
        .ld_asid(ld_asid), .ld_sz(ld_sz), .ld_shared(ld_shared), .ld_perm(ld_perm),
        .ld_dirty(ld_dirty), .ld_ppn(ld_ppn), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_pa(rsp_pa), .repl_ptr(repl_ptr)
    );

    // {acc, priv, xlate_en, single_space, cur_asid, va, exp_code, exp_pa}
    localparam logic [VW-1:0] VEC [NV] = '{
        // R1 privileged untranslated regions
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h81234567,12'h000,32'h01234567},
        {2'd1,1'b1,1'b1,1'b0,8'h11,32'hA0000010,12'h000,32'h00000010},
        {2'd2,1'b1,1'b1,1'b0,8'h11,32'hFF000008,12'h000,32'hFF000008},
        // R2 user access to untranslated regions
        {2'd0,1'b0,1'b1,1'b0,8'h11,32'h80000000,12'h0C0,32'h00000000},
        {2'd2,1'b0,1'b1,1'b0,8'h11,32'hBFFFFFFC,12'h0C0,32'h00000000},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'hE4000000,12'h100,32'h00000000},
        {2'd0,1'b0,1'b1,1'b0,8'h11,32'hE0000040,12'h000,32'hE0000040},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'hE3FFFFFC,12'h000,32'hE3FFFFFC},
        {2'd1,1'b0,1'b0,1'b0,8'h11,32'hA0000000,12'h100,32'h00000000},
        // R3 translation off
        {2'd0,1'b0,1'b0,1'b0,8'h11,32'hC1234567,12'h000,32'h01234567},
        {2'd1,1'b1,1'b0,1'b0,8'h11,32'h7FFFFFFF,12'h000,32'h1FFFFFFF},
        // R4 page sizes and address composition
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00010123,12'h000,32'h0048D123},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'h000103FF,12'h000,32'h0048D3FF},
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00010400,12'h040,32'h00000000},
        {2'd2,1'b0,1'b1,1'b0,8'h33,32'h0020ABCD,12'h000,32'h0100ABCD},
        {2'd0,1'b0,1'b1,1'b0,8'h33,32'h0020FFFF,12'h000,32'h0100FFFF},
        {2'd0,1'b0,1'b1,1'b0,8'h33,32'h00210000,12'h040,32'h00000000},
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00300456,12'h000,32'h00040456},
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h005ABCDE,12'h000,32'h1FFABCDE},
        {2'd2,1'b0,1'b1,1'b0,8'h11,32'h005FFFFF,12'h000,32'h1FFFFFFF},
        // R5 tag gating
        {2'd0,1'b1,1'b1,1'b0,8'h33,32'h00010123,12'h040,32'h00000000},
        {2'd0,1'b1,1'b1,1'b1,8'h33,32'h00010123,12'h000,32'h0048D123},
        {2'd0,1'b0,1'b1,1'b1,8'h33,32'h00010123,12'h040,32'h00000000},
        {2'd3,1'b0,1'b1,1'b0,8'h77,32'h0020ABCD,12'h000,32'h0100ABCD},
        // R6 multiple hit
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00700010,12'h140,32'h00000000},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'h007003FF,12'h140,32'h00000000},
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00700800,12'h000,32'h00002800},
        // R7 misses (invalid entry and empty space)
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'h00900000,12'h040,32'h00000000},
        {2'd1,1'b1,1'b1,1'b0,8'h11,32'h00900000,12'h060,32'h00000000},
        {2'd2,1'b0,1'b1,1'b0,8'h11,32'h00900000,12'h040,32'h00000000},
        {2'd0,1'b1,1'b1,1'b0,8'h11,32'hC0000000,12'h040,32'h00000000},
        // R8 user permission
        {2'd0,1'b0,1'b1,1'b0,8'h11,32'h00300456,12'h0A0,32'h00000000},
        {2'd2,1'b0,1'b1,1'b0,8'h11,32'h00300456,12'h0A0,32'h00000000},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'h00300456,12'h0C0,32'h00000000},
        // R9 write permission and dirty
        {2'd1,1'b1,1'b1,1'b0,8'h11,32'h00300456,12'h0C0,32'h00000000},
        {2'd1,1'b0,1'b1,1'b0,8'h33,32'h0020ABCD,12'h0C0,32'h00000000},
        {2'd1,1'b1,1'b1,1'b0,8'h11,32'h005ABCDE,12'h080,32'h00000000},
        {2'd0,1'b0,1'b1,1'b0,8'h11,32'h005ABCDE,12'h000,32'h1FFABCDE},
        {2'd1,1'b0,1'b1,1'b0,8'h11,32'h00010123,12'h000,32'h0048D123},
        {2'd1,1'b1,1'b1,1'b0,8'h11,32'h00700800,12'h000,32'h00002800}
    };

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic access(input logic [1:0] a, input logic p, input logic x,
                          input logic s, input logic [7:0] t, input logic [31:0] v);
        @(negedge clk);
        acc = a; priv = p; xlate_en = x; single_space = s; cur_asid = t; va = v;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic load(input logic vld, input logic [21:0] vpn, input logic [7:0] tag,
                        input logic [1:0] sz, input logic sh, input logic [1:0] pm,
                        input logic d, input logic [18:0] ppn);
        @(negedge clk);
        ld_en = 1'b1; ld_valid = vld; ld_vpn = vpn; ld_asid = tag; ld_sz = sz;
        ld_shared = sh; ld_perm = pm; ld_dirty = d; ld_ppn = ppn;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic bump();
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00F00000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = 1'b0; ld_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; req = 1'b0; acc = 2'd0; va = '0; priv = 1'b1; xlate_en = 1'b1;
        single_space = 1'b0; cur_asid = 8'h11; wrap_lim = '0; ld_en = 1'b0;
        ld_valid = 1'b0; ld_vpn = '0; ld_asid = '0; ld_sz = '0; ld_shared = 1'b0;
        ld_perm = '0; ld_dirty = 1'b0; ld_ppn = '0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 valid", 32'(rsp_valid), 32'd0);
        check("R13 code", 32'(rsp_code), 32'd0);
        check("R13 ptr", 32'(repl_ptr), 32'd0);
        rst = 1'b0;

        // Table of entries, one slot each, pointer stepped by a miss between loads
        load(1'b1, 22'h000040, 8'h11, 2'd0, 1'b0, 2'd3, 1'b1, 19'h01234); bump();
        load(1'b1, 22'h000800, 8'h22, 2'd2, 1'b1, 2'd2, 1'b1, 19'h04000); bump();
        load(1'b1, 22'h000C00, 8'h11, 2'd1, 1'b0, 2'd0, 1'b0, 19'h00100); bump();
        load(1'b1, 22'h001455, 8'h11, 2'd3, 1'b0, 2'd3, 1'b0, 19'h7FC33); bump();
        load(1'b1, 22'h001C00, 8'h11, 2'd0, 1'b0, 2'd3, 1'b1, 19'h00001); bump();
        load(1'b1, 22'h001C01, 8'h11, 2'd1, 1'b0, 2'd3, 1'b1, 19'h00008); bump();
        load(1'b0, 22'h002400, 8'h11, 2'd0, 1'b1, 2'd3, 1'b1, 19'h00055); bump();

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            access(v[88:87], v[86], v[85], v[84], v[83:76], v[75:44]);
            check($sformatf("R12 valid vec %0d", i), 32'(rsp_valid), 32'd1);
            check($sformatf("R1-9 code vec %0d", i), 32'(rsp_code), 32'(v[43:32]));
            check($sformatf("R4 pa vec %0d", i), rsp_pa, v[31:0]);
        end

        // R12 valid drops and result holds without request
        @(negedge clk);
        check("R12 valid low", 32'(rsp_valid), 32'd0);
        check("R12 hold pa", rsp_pa, 32'h00002800);

        // R13 reset invalidates entries
        do_reset();
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00010123);
        check("R13 entry cleared", 32'(rsp_code), 32'h040);

        // R10 pointer with small wrap limit
        do_reset();
        wrap_lim = IDX_W'(3);
        exp_ptr = 0;
        for (int k = 0; k < 5; k++) begin
            bump();
            exp_ptr = (exp_ptr + 1 > 3) ? 0 : exp_ptr + 1;
            check("R10 step lim3", 32'(repl_ptr), 32'(exp_ptr));
        end
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h80000000);
        check("R10 bypass no step", 32'(repl_ptr), 32'(exp_ptr));
        access(2'd0, 1'b1, 1'b0, 1'b0, 8'h11, 32'h00001000);
        check("R10 xlate off no step", 32'(repl_ptr), 32'(exp_ptr));

        // R10 full range with zero limit
        wrap_lim = '0;
        for (int k = 0; k < ENTRIES - 1; k++) begin
            bump();
            exp_ptr = (exp_ptr + 1 > ENTRIES - 1) ? 0 : exp_ptr + 1;
        end
        check("R10 wrap full", 32'(repl_ptr), 32'(exp_ptr));

        // R11 loads land at the pointer and do not move it
        do_reset();
        wrap_lim = IDX_W'(1);
        load(1'b1, 22'h000040, 8'h11, 2'd0, 1'b0, 2'd3, 1'b1, 19'h00010);
        check("R11 load keeps ptr", 32'(repl_ptr), 32'd0);
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00010004);
        check("R11 slot0 A", rsp_pa, 32'h00004004);
        load(1'b1, 22'h000080, 8'h11, 2'd0, 1'b0, 2'd3, 1'b1, 19'h00020);
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00020008);
        check("R11 slot1 B", rsp_pa, 32'h00008008);
        check("R10 wrap lim1", 32'(repl_ptr), 32'd0);
        load(1'b1, 22'h0000C0, 8'h11, 2'd0, 1'b0, 2'd3, 1'b1, 19'h00030);
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00010004);
        check("R11 A overwritten", 32'(rsp_code), 32'h040);
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h0003000C);
        check("R11 C in slot0", rsp_pa, 32'h0000C00C);
        access(2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 32'h00020008);
        check("R11 B kept", rsp_pa, 32'h00008008);

        summary();
    end
endmodule